// File: doc/BRIEF.md
# Token Register File Control Module

This block is the control-path shadow of a register file that has one write port and two read ports. It handles the write side and the read side separately. On the write side, a token receiver watches one token line per write-mux source. When a token arrives, the block asks the control memory for the write-address field and raises the write enable. It also gives the datapath a binary select code for the write mux. At the clock edge it stores the token's valid (staging-predicate) bit in a one-bit register file. That register file has the same depth and ports as the data register file.

A token stream ends when it reaches the register file. The read ports never receive tokens. Instead, a token-generation pulse from the control memory re-creates a token on a read port. During that pulse the read port requests its read-address field and its dest fields, and looks up the stored valid bit at the read address. Its token sender then drives a token to up to two consumers, and each token carries that stored bit. The block exists so that the staging predicate survives between the point where a token ends and the point where it is re-created.

Top module: `tok_rf_ctrl`

## Requirements
- R1: In any cycle where some write token line is high, wr_addr_req_o and wr_en_o are both 1 in that same cycle. When no line is high, both are 0.
- R2: While exactly one write token line i is high, wr_sel_o equals i in binary. With no token, wr_sel_o is 0.
- R3: At the clock edge of a write-token cycle, the shadow entry at wr_addr_i takes the wr_vld_i bit of the source whose token is high. From the next cycle on, a read of that address returns this bit.
- R4: A read of the address being written in the same cycle returns the bit stored before that edge.
- R5: While rd_gen_i[p] is 0, read port p raises no field request and drives no token and no valid bit, whatever its dest fields hold.
- R6: While rd_gen_i[p] is 1, read port p drives rd_addr_req_o[p] and rd_dest_req_o[p] to 1.
- R7: Each read port has two dest fields of 3 bits each. Field j of port p is bits [(p*2+j)*3 +: 3] of rd_dest_i. While rd_gen_i[p] is 1, a field value k in 1..4 drives consumer bit k-1, which is bit p*4+k-1 of rd_tok_o. A value of 0 or of 5..7 drives nothing. The two fields combine by OR.
- R8: The valid bit of each token sent equals the stored bit at that port's rd_addr_i. rd_vld_o is 1 only where rd_tok_o is 1.
- R9: When clr_i is 1 at a clock edge, every stored bit becomes 0, even if a write to a stored bit happens in the same cycle.
- R10: After the asynchronous reset, every stored bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| clr_i | input | 1 | synchronous clear of all stored valid bits |
| wr_tok_i | input | 4 | incoming write token, one line per mux source, at most one high |
| wr_vld_i | input | 4 | valid bit carried on each write token line |
| wr_addr_i | input | 3 | write address field from the decoder |
| wr_addr_req_o | output | 1 | request for the write-address field |
| wr_en_o | output | 1 | write enable to the data register file |
| wr_sel_o | output | 2 | binary select code for the write mux |
| rd_gen_i | input | 2 | token-generation pulse per read port |
| rd_addr_i | input | 6 | read address per port, 3 bits each |
| rd_dest_i | input | 12 | two 3-bit dest fields per port |
| rd_addr_req_o | output | 2 | read-address field request per port |
| rd_dest_req_o | output | 2 | dest field request per port |
| rd_tok_o | output | 8 | token per consumer, 4 consumers per port |
| rd_vld_o | output | 8 | valid bit carried with each token |

## Verification
The bench writes both valid values into every address from every write source. After each write it reads the address back through the read port picked by the address's parity. This separates a wrong entry, a wrong source selection and a dropped write. A full sweep of both dest fields on both ports, with generation on, checks the decode of codes 0..7 and the OR of two fields. The same fields with generation off must give silence. A write and a read of the same address in one cycle shows whether the read returns the old bit. A clear issued together with a write shows which of the two wins.

// File: rtl/tok_rf_pkg.sv
package tok_rf_pkg;
  // Dest code k (1..n) addresses consumer k-1; 0 means unused.
  function automatic logic dest_hit(input int unsigned code, input int unsigned cons);
    return code == cons + 1;
  endfunction
endpackage

// File: rtl/tok_rcv.sv
module tok_rcv #(
  parameter int NUM_SRC = 4,
  localparam int SW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] tok_i,
  input  logic [NUM_SRC-1:0] vld_i,
  output logic               has_tok_o,
  output logic               vld_o,
  output logic [SW-1:0]      sel_o
);
  assign has_tok_o = |tok_i;
  assign vld_o     = |(tok_i & vld_i);

  // OR-gate encoder: select bit b collects every source whose index has bit b set
  for (genvar b = 0; b < SW; b++) begin : g_bit
    logic [NUM_SRC-1:0] mask;
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      assign mask[i] = ((i >> b) & 1) == 1;
    end
    assign sel_o[b] = |(tok_i & mask);
  end
endmodule

// File: rtl/tok_snd.sv
module tok_snd
  import tok_rf_pkg::*;
#(
  parameter int NUM_DEST = 2,
  parameter int NUM_CONS = 4,
  localparam int DW = $clog2(NUM_CONS + 1)
) (
  input  logic                   en_i,
  input  logic                   vld_i,
  input  logic [NUM_DEST*DW-1:0] dest_i,
  output logic [NUM_CONS-1:0]    tok_o,
  output logic [NUM_CONS-1:0]    vld_o
);
  for (genvar c = 0; c < NUM_CONS; c++) begin : g_cons
    logic [NUM_DEST-1:0] hit;
    for (genvar j = 0; j < NUM_DEST; j++) begin : g_dst
      assign hit[j] = dest_hit(int'(dest_i[j*DW +: DW]), c);
    end
    assign tok_o[c] = en_i & (|hit);
    assign vld_o[c] = tok_o[c] & vld_i;
  end
endmodule

// File: rtl/vbit_rf.sv
module vbit_rf #(
  parameter int DEPTH  = 8,
  parameter int NUM_RD = 2,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               we_i,
  input  logic [AW-1:0]      waddr_i,
  input  logic               wbit_i,
  input  logic [NUM_RD*AW-1:0] raddr_i,
  output logic [NUM_RD-1:0]  rbit_o
);
  logic [DEPTH-1:0] bits_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    bits_q <= '0;
    else if (clr_i) bits_q <= '0;
    else if (we_i)  bits_q[waddr_i] <= wbit_i;
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    assign rbit_o[p] = bits_q[raddr_i[p*AW +: AW]];
  end
endmodule

// File: rtl/tok_rf_ctrl.sv
module tok_rf_ctrl #(
  parameter int NUM_SRC  = 4,
  parameter int DEPTH    = 8,
  parameter int NUM_RD   = 2,
  parameter int NUM_DEST = 2,
  parameter int NUM_CONS = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int SW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int DW = $clog2(NUM_CONS + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          clr_i,
  input  logic [NUM_SRC-1:0]            wr_tok_i,
  input  logic [NUM_SRC-1:0]            wr_vld_i,
  input  logic [AW-1:0]                 wr_addr_i,
  output logic                          wr_addr_req_o,
  output logic                          wr_en_o,
  output logic [SW-1:0]                 wr_sel_o,
  input  logic [NUM_RD-1:0]             rd_gen_i,
  input  logic [NUM_RD*AW-1:0]          rd_addr_i,
  input  logic [NUM_RD*NUM_DEST*DW-1:0] rd_dest_i,
  output logic [NUM_RD-1:0]             rd_addr_req_o,
  output logic [NUM_RD-1:0]             rd_dest_req_o,
  output logic [NUM_RD*NUM_CONS-1:0]    rd_tok_o,
  output logic [NUM_RD*NUM_CONS-1:0]    rd_vld_o
);
  logic              has_tok;
  logic              wbit;
  logic [NUM_RD-1:0] rbit;

  tok_rcv #(.NUM_SRC(NUM_SRC)) u_rcv (
    .tok_i(wr_tok_i), .vld_i(wr_vld_i),
    .has_tok_o(has_tok), .vld_o(wbit), .sel_o(wr_sel_o)
  );

  assign wr_addr_req_o = has_tok;
  assign wr_en_o       = has_tok;

  vbit_rf #(.DEPTH(DEPTH), .NUM_RD(NUM_RD)) u_vrf (
    .clk_i, .rst_ni, .clr_i,
    .we_i(has_tok), .waddr_i(wr_addr_i), .wbit_i(wbit),
    .raddr_i(rd_addr_i), .rbit_o(rbit)
  );

  for (genvar p = 0; p < NUM_RD; p++) begin : g_port
    assign rd_addr_req_o[p] = rd_gen_i[p];
    assign rd_dest_req_o[p] = rd_gen_i[p];
    tok_snd #(.NUM_DEST(NUM_DEST), .NUM_CONS(NUM_CONS)) u_snd (
      .en_i(rd_gen_i[p]), .vld_i(rbit[p]),
      .dest_i(rd_dest_i[p*NUM_DEST*DW +: NUM_DEST*DW]),
      .tok_o(rd_tok_o[p*NUM_CONS +: NUM_CONS]),
      .vld_o(rd_vld_o[p*NUM_CONS +: NUM_CONS])
    );
  end
endmodule

// File: rtl/tok_rf_ctrl_chk.sv
module tok_rf_ctrl_chk #(
  parameter int NUM_SRC  = 4,
  parameter int NUM_RD   = 2,
  parameter int NUM_CONS = 4,
  localparam int SW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       clr_i,
  input logic [NUM_SRC-1:0]         wr_tok_i,
  input logic                       wr_addr_req_o,
  input logic                       wr_en_o,
  input logic [SW-1:0]              wr_sel_o,
  input logic [NUM_RD-1:0]          rd_gen_i,
  input logic [NUM_RD-1:0]          rd_addr_req_o,
  input logic [NUM_RD-1:0]          rd_dest_req_o,
  input logic [NUM_RD*NUM_CONS-1:0] rd_tok_o,
  input logic [NUM_RD*NUM_CONS-1:0] rd_vld_o
);
  AST_WR_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_addr_req_o == (|wr_tok_i)) && (wr_en_o == (|wr_tok_i))); // R1
  AST_WR_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($onehot0(wr_tok_i) && wr_en_o) |-> wr_tok_i[wr_sel_o]); // R2
  AST_VLD_IN_TOK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_vld_o & ~rd_tok_o) == '0); // R8
  AST_CLR_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> rd_vld_o == '0); // R9

  for (genvar p = 0; p < NUM_RD; p++) begin : g_p
    AST_GEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_gen_i[p] |-> (rd_tok_o[p*NUM_CONS +: NUM_CONS] == '0) && !rd_addr_req_o[p]); // R5
    AST_GEN_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_gen_i[p] |-> rd_addr_req_o[p] && rd_dest_req_o[p]); // R6
  end
endmodule

bind tok_rf_ctrl tok_rf_ctrl_chk #(.NUM_SRC(NUM_SRC), .NUM_RD(NUM_RD), .NUM_CONS(NUM_CONS)) u_chk (.*);

// File: tb/test_tok_rf_ctrl.sv
module test_tok_rf_ctrl;
  localparam int NS = 4, DEP = 8, NR = 2, ND = 2, NC = 4, AW = 3, DW = 3;

  logic clk_i = 0, rst_ni = 0, clr_i = 0;
  logic [NS-1:0] wr_tok_i = '0, wr_vld_i = '0;
  logic [AW-1:0] wr_addr_i = '0;
  logic wr_addr_req_o, wr_en_o;
  logic [1:0] wr_sel_o;
  logic [NR-1:0] rd_gen_i = '0;
  logic [NR*AW-1:0] rd_addr_i = '0;
  logic [NR*ND*DW-1:0] rd_dest_i = '0;
  logic [NR-1:0] rd_addr_req_o, rd_dest_req_o;
  logic [NR*NC-1:0] rd_tok_o, rd_vld_o;

  int tests = 0, fails = 0;
  logic model [DEP];

  tok_rf_ctrl i_tok_rf_ctrl (.*);

  always #4 clk_i = ~clk_i;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NC-1:0] exp_tok(int d0, int d1);
    logic [NC-1:0] t = '0;
    if (d0 >= 1 && d0 <= NC) t[d0-1] = 1'b1;
    if (d1 >= 1 && d1 <= NC) t[d1-1] = 1'b1;
    return t;
  endfunction

  // Drive one read port (the other idle), evaluate before the next edge
  task automatic rd_set(int p, int a, int d0, int d1, logic gen);
    rd_gen_i = '0; rd_addr_i = '0; rd_dest_i = '0;
    rd_gen_i[p] = gen;
    rd_addr_i[p*AW +: AW] = AW'(a);
    rd_dest_i[(p*ND)*DW +: DW] = DW'(d0);
    rd_dest_i[(p*ND+1)*DW +: DW] = DW'(d1);
    #1;
  endtask

  task automatic rd_chk(string req, int p, int a, int d0, int d1);
    logic [NC-1:0] t;
    rd_set(p, a, d0, d1, 1'b1);
    t = exp_tok(d0, d1);
    check(req, 32'(rd_tok_o), 32'(t) << (p*NC));
    check(req, 32'(rd_vld_o), 32'(t & {NC{model[a]}}) << (p*NC));
  endtask

  task automatic wr(int a, int src, logic v);
    @(negedge clk_i);
    wr_tok_i = '0; wr_tok_i[src] = 1'b1;
    wr_vld_i = ~{NS{v}}; wr_vld_i[src] = v;
    wr_addr_i = AW'(a);
    #1;
    check("R1", {30'd0, wr_addr_req_o, wr_en_o}, 32'd3);
    check("R2", 32'(wr_sel_o), 32'(src));
    @(negedge clk_i);
    wr_tok_i = '0; wr_vld_i = '0;
    model[a] = v;
  endtask

  initial begin
    for (int i = 0; i < DEP; i++) model[i] = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    #1;
    check("R1", {30'd0, wr_addr_req_o, wr_en_o}, 32'd0);
    check("R2", 32'(wr_sel_o), 32'd0);
    for (int a = 0; a < DEP; a++) rd_chk("R10", a % NR, a, 1, 2);

    // R3: every address, every source, both valid values
    for (int a = 0; a < DEP; a++)
      for (int s = 0; s < NS; s++)
        for (int v = 0; v < 2; v++) begin
          wr(a, s, v[0]);
          rd_chk("R3", a % NR, a, 3, 4);
          rd_set(0, 0, 0, 0, 1'b0);
        end

    // R7/R8: dest sweep with generation on; R5/R6 on the same fields
    wr(5, 1, 1'b1);
    for (int p = 0; p < NR; p++)
      for (int d0 = 0; d0 < 8; d0++)
        for (int d1 = 0; d1 < 8; d1++) begin
          rd_chk("R7", p, 5, d0, d1);
          check("R6", {30'd0, rd_addr_req_o[p], rd_dest_req_o[p]}, 32'd3);
          rd_set(p, 5, d0, d1, 1'b0);
          check("R5", {rd_tok_o, rd_vld_o, 14'd0, rd_addr_req_o, rd_dest_req_o}, 32'd0);
        end
    rd_chk("R8", 1, 4, 1, 4);
    rd_chk("R8", 0, 5, 2, 0);

    // R4: write and read the same address in one cycle
    @(negedge clk_i);
    wr_tok_i = 4'b1000; wr_vld_i = 4'b1000; wr_addr_i = 3'd2;
    model[2] = 1'b0;
    wr(2, 0, 1'b0);
    @(negedge clk_i);
    wr_tok_i = 4'b0100; wr_vld_i = 4'b0100; wr_addr_i = 3'd2;
    rd_set(1, 2, 1, 0, 1'b1);
    check("R4", 32'(rd_vld_o), 32'h0);
    @(negedge clk_i);
    wr_tok_i = '0; wr_vld_i = '0;
    model[2] = 1'b1;
    rd_chk("R4", 1, 2, 1, 0);

    // R9: fill with ones, then clear together with a write
    for (int a = 0; a < DEP; a++) wr(a, a % NS, 1'b1);
    @(negedge clk_i);
    clr_i = 1; wr_tok_i = 4'b0001; wr_vld_i = 4'b0001; wr_addr_i = 3'd3;
    @(negedge clk_i);
    clr_i = 0; wr_tok_i = '0; wr_vld_i = '0;
    for (int a = 0; a < DEP; a++) model[a] = 1'b0;
    for (int a = 0; a < DEP; a++) rd_chk("R9", a % NR, a, 1, 3);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    fails++; tests++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule